// File: doc/BRIEF.md
# Serial Command and FIFO Access Front End

This block is the slave side of a four-wire serial link whose select line is active high. Each frame opens with an eight-bit header: a two-bit mode code, then a six-bit command field. The block recognises three kinds of frame. A command frame hands a six-bit code to the core. A load frame turns the payload into transmit bytes pushed to the core. A read frame shifts bytes taken from the core's receive queue out on the serial data output.

All serial inputs are oversampled in the system clock domain through a synchroniser, so the serial clock must be well below the system clock. A command is not issued when its last bit arrives. It is issued only when the host lowers select, which lets the host cancel a command by ending the frame early. On a load, a byte cut short by select falling is dropped. On a read, a byte is removed from the receive queue only after all of its bits have left, so an interrupted byte is sent again at the start of the next read.

Top module: `spi_cmd_front`

## Requirements
- R1: The sampled header bits use the following encoding. Bit 7 is the first bit after select rises and bit 0 is the eighth. Bits 7:6 are the mode: 11 = command, 10 = queue access. Bits 5:0 are the command field, bit 5 first. Every input bit is sampled on the falling edge of the serial clock.
- R2: In a command frame whose full header has arrived, `cmd_strobe` pulses for exactly one clock after select falls, and `cmd_code` carries bits 5:0 of the header. No strobe occurs before select falls.
- R3: In a queue-access frame with command field 000000, every complete following byte (MSB first) is presented on `tx_data` with a one-clock `tx_push` pulse, in arrival order.
- R4: On a load frame, a payload byte with fewer than 8 bits when select falls is not pushed.
- R5: On one load frame at most 32 bytes are pushed. Any further byte is dropped and sets `tx_overflow`, which stays set until reset.
- R6: In a queue-access frame with command field 111111, `sdo` presents the receive bytes MSB first. Each bit changes on a serial clock rising edge, starting at the first rising edge after the header.
- R7: `rx_pop` pulses once after the eighth bit of a byte has been driven. If select falls earlier, nothing is popped and the same byte is the first one sent by the next read.
- R8: A read of an empty receive queue drives zeros, produces no pop, and sets `rx_underflow`, which stays set until reset.
- R9: A frame that starts while `exec_busy` is high is ignored: no strobe, push or pop results from it.
- R10: Mode 0x, and queue-access command fields other than 000000 and 111111, produce no strobe, push or pop.
- R11: While and after `rst` is asserted, all outputs are 0.
- R12: Select going low clears the header and bit counters, so a frame aborted mid-header has no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sen | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| exec_busy | input | 1 | Core is still executing the previous command |
| cmd_strobe | output | 1 | One-clock command pulse |
| cmd_code | output | 6 | Command code |
| tx_push | output | 1 | Transmit byte valid pulse |
| tx_data | output | 8 | Transmit byte |
| tx_overflow | output | 1 | Sticky: load exceeded the byte cap |
| rx_pop | output | 1 | Remove head of receive queue |
| rx_data | input | 8 | Head of receive queue (show-ahead) |
| rx_empty | input | 1 | Receive queue is empty |
| rx_underflow | output | 1 | Sticky: read from empty queue |

## Verification
The table walks header patterns that differ in one field at a time. These are command codes at both extremes and in the middle, load frames with one and two bytes, the near-miss field 000001, and a mode 01 header. Together they show whether the mode bits and the command field are decoded separately and in the right bit order. Directed frames then end a load and a read part-way through a byte, which separates dropping a partial write from putting a partial read back. A 34-byte load, an empty read, a busy-start frame and a header aborted after five bits check the cap, the zero fill and the counter clearing.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int MODE_W = 2;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_CMD  = 2'b11;
  localparam mode_t MODE_FIFO = 2'b10;

  typedef enum logic [2:0] {
    F_IDLE, F_HDR, F_CMD, F_LOAD, F_READ, F_SKIP
  } frame_st_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= async_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = prev & ~level;
endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
  import spi_fe_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sen_s,
  input  logic              sen_rise,
  input  logic              sen_fall,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic              exec_busy,
  output logic              cmd_strobe,
  output logic [CODE_W-1:0] cmd_code,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_overflow,
  output logic              rd_active
);
  localparam int HDR_W = MODE_W + CODE_W;
  localparam int LONG  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(LONG);
  localparam int NB_W  = $clog2(MAX_BYTES + 1);

  frame_st_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [LONG-1:0]   shreg, next_sh;
  logic [CODE_W-1:0] held_code;
  logic [NB_W-1:0]   nbytes;
  frame_st_t         decoded;

  assign next_sh = {shreg[LONG-2:0], sdi_s};

  always_comb begin
    decoded = F_SKIP;
    if (next_sh[HDR_W-1 -: MODE_W] == MODE_CMD)
      decoded = F_CMD;
    else if (next_sh[HDR_W-1 -: MODE_W] == MODE_FIFO) begin
      if (next_sh[CODE_W-1:0] == '0)      decoded = F_LOAD;
      else if (&next_sh[CODE_W-1:0])      decoded = F_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= F_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      held_code   <= '0;
      nbytes      <= '0;
      cmd_strobe  <= 1'b0;
      cmd_code    <= '0;
      tx_push     <= 1'b0;
      tx_data     <= '0;
      tx_overflow <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      tx_push    <= 1'b0;
      if (!sen_s) begin
        if (sen_fall && state == F_CMD) begin
          cmd_strobe <= 1'b1;
          cmd_code   <= held_code;
        end
        state  <= F_IDLE;
        cnt    <= '0;
        nbytes <= '0;
      end else if (sen_rise) begin
        state <= exec_busy ? F_SKIP : F_HDR;
        cnt   <= '0;
      end else if (sclk_fall) begin
        shreg <= next_sh;
        case (state)
          F_HDR: begin
            if (cnt == CNT_W'(HDR_W - 1)) begin
              cnt       <= '0;
              state     <= decoded;
              held_code <= next_sh[CODE_W-1:0];
            end else cnt <= cnt + 1'b1;
          end
          F_LOAD: begin
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt <= '0;
              if (nbytes < NB_W'(MAX_BYTES)) begin
                tx_push <= 1'b1;
                tx_data <= next_sh[DATA_W-1:0];
                nbytes  <= nbytes + 1'b1;
              end else tx_overflow <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active = (state == F_READ);

  a_r2_strobe_on_select_fall: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> $past(sen_fall));
  a_r9_busy_frame_skipped: assert property (@(posedge clk) disable iff (rst)
    (sen_rise && exec_busy) |=> (state == F_SKIP));
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(tx_overflow) |-> tx_overflow);
  a_r5_push_within_cap: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> (nbytes <= NB_W'(MAX_BYTES)) && (nbytes != '0));
  a_r3_push_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_push);
endmodule

// File: rtl/spi_fe_readout.sv
module spi_fe_readout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_active,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_empty,
  output logic              sdo,
  output logic              rx_pop,
  output logic              rx_underflow
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [BIT_W-1:0]  bitidx;
  logic [DATA_W-1:0] sh;
  logic              have_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitidx       <= '0;
      sh           <= '0;
      have_byte    <= 1'b0;
      sdo          <= 1'b0;
      rx_pop       <= 1'b0;
      rx_underflow <= 1'b0;
    end else begin
      rx_pop <= 1'b0;
      if (!rd_active) begin
        bitidx    <= '0;
        sdo       <= 1'b0;
        have_byte <= 1'b0;
      end else if (sclk_rise) begin
        if (bitidx == '0) begin
          sdo       <= rx_empty ? 1'b0 : rx_data[DATA_W-1];
          sh        <= rx_empty ? '0 : (rx_data << 1);
          have_byte <= !rx_empty;
          if (rx_empty) rx_underflow <= 1'b1;
        end else begin
          sdo <= sh[DATA_W-1];
          sh  <= sh << 1;
        end
        if (bitidx == BIT_W'(DATA_W - 1)) begin
          bitidx <= '0;
          rx_pop <= have_byte;
        end else bitidx <= bitidx + 1'b1;
      end
    end
  end

  a_r7_pop_follows_rise: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(sclk_rise) && $past(rd_active));
  a_r7_pop_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop);
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(rx_underflow) |-> rx_underflow);
  a_r6_sdo_quiet_outside_read: assert property (@(posedge clk) disable iff (rst)
    $past(!rd_active) |-> !sdo);
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
  parameter int CODE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 32,
  parameter int SYNC_ST   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sen,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic              exec_busy,
  output logic              cmd_strobe,
  output logic [CODE_W-1:0] cmd_code,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_overflow,
  output logic              rx_pop,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_empty,
  output logic              rx_underflow
);
  localparam int SEN_B = 2, SCK_B = 1, DAT_B = 0;

  logic [2:0] lvl, rs, fl;
  logic       rd_active;

  spi_fe_sync #(.W(3), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .async_in({sen, sclk, sdi}),
    .level(lvl), .rise(rs), .fall(fl)
  );

  spi_fe_frame #(.CODE_W(CODE_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) u_frame (
    .clk(clk), .rst(rst),
    .sen_s(lvl[SEN_B]), .sen_rise(rs[SEN_B]), .sen_fall(fl[SEN_B]),
    .sclk_fall(fl[SCK_B]), .sdi_s(lvl[DAT_B]), .exec_busy(exec_busy),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .tx_push(tx_push), .tx_data(tx_data), .tx_overflow(tx_overflow),
    .rd_active(rd_active)
  );

  spi_fe_readout #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_active(rd_active), .sclk_rise(rs[SCK_B]),
    .rx_data(rx_data), .rx_empty(rx_empty),
    .sdo(sdo), .rx_pop(rx_pop), .rx_underflow(rx_underflow)
  );

  a_r10_one_action_at_a_time: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_strobe, tx_push, rx_pop}));
endmodule

// File: tb/spi_cmd_front_test.sv
module spi_cmd_front_test;
  logic clk = 1'b0, rst = 1'b1;
  logic sen = 1'b0, sclk = 1'b0, sdi = 1'b0, exec_busy = 1'b0;
  logic sdo, cmd_strobe, tx_push, tx_overflow, rx_pop, rx_empty, rx_underflow;
  logic [5:0] cmd_code;
  logic [7:0] tx_data, rx_data;

  always #5 clk = ~clk;

  spi_cmd_front uut (
    .clk(clk), .rst(rst), .sen(sen), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .exec_busy(exec_busy), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .tx_push(tx_push), .tx_data(tx_data), .tx_overflow(tx_overflow),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .rx_underflow(rx_underflow)
  );

  // core-side receive queue model and output monitors
  logic [7:0] rxmem [16];
  int rx_head = 0, rx_tail = 0;
  assign rx_empty = (rx_head == rx_tail);
  assign rx_data  = rxmem[rx_head[3:0]];

  int n_str = 0, n_push = 0, n_pop = 0;
  logic [5:0] last_code = '0;
  logic [7:0] pushed [64];

  always @(posedge clk) begin
    if (rst) rx_head <= 0;
    else if (rx_pop) rx_head <= rx_head + 1;
    if (cmd_strobe) begin n_str <= n_str + 1; last_code <= cmd_code; end
    if (tx_push) begin pushed[n_push[5:0]] <= tx_data; n_push <= n_push + 1; end
    if (rx_pop) n_pop <= n_pop + 1;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int n, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sdi  = b[7-i];
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      got  = {got[6:0], sdo};
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic sel_on();
    sen = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (4) @(negedge clk);
    sen = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // {header, payload bytes, expected strobes, expected pushes}
  localparam logic [12:0] VEC [0:7] = '{
    {8'hC5, 2'd0, 1'b1, 2'd0},
    {8'hFF, 2'd0, 1'b1, 2'd0},
    {8'hC0, 2'd0, 1'b1, 2'd0},
    {8'hDA, 2'd0, 1'b1, 2'd0},
    {8'h80, 2'd2, 1'b0, 2'd2},
    {8'h80, 2'd1, 1'b0, 2'd1},
    {8'h81, 2'd2, 1'b0, 2'd0},
    {8'h40, 2'd1, 1'b0, 2'd0}
  };

  initial begin
    logic [7:0] g;
    int s0, p0, q0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 outputs in reset", {sdo, cmd_strobe, tx_push, tx_overflow, rx_pop, rx_underflow}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 outputs after reset", {sdo, cmd_strobe, tx_push, tx_overflow, rx_pop, rx_underflow, cmd_code, tx_data}, 0);

    // table walk: R1 R2 R3 R10
    for (int v = 0; v < 8; v++) begin
      s0 = n_str; p0 = n_push;
      sel_on();
      xfer(VEC[v][12:5], 8, g);
      for (int k = 0; k < int'(VEC[v][4:3]); k++) xfer(8'h3C + 8'(17*k) + 8'(v), 8, g);
      repeat (4) @(negedge clk);
      check("R2 no strobe before select falls", n_str - s0, 0);
      sel_off();
      check("R1/R2/R10 strobe count", n_str - s0, int'(VEC[v][2]));
      if (VEC[v][2]) check("R1 R2 command code", last_code, int'(VEC[v][10:5]));
      check("R3/R10 push count", n_push - p0, int'(VEC[v][1:0]));
      for (int k = 0; k < int'(VEC[v][1:0]); k++)
        check("R3 pushed byte", pushed[6'(p0 + k)], int'(8'h3C + 8'(17*k) + 8'(v)));
    end
    check("R10 no pops from table", n_pop, 0);

    // R4 partial load byte dropped
    p0 = n_push;
    sel_on(); xfer(8'h80, 8, g); xfer(8'h96, 8, g); xfer(8'hFF, 5, g); sel_off();
    check("R4 partial byte dropped", n_push - p0, 1);
    check("R4 full byte kept", pushed[6'(p0)], 8'h96);

    // R12 aborted header then clean frame
    s0 = n_str;
    sel_on(); xfer(8'hC0, 5, g); sel_off();
    check("R12 aborted header no strobe", n_str - s0, 0);
    sel_on(); xfer(8'hC9, 8, g); sel_off();
    check("R12 fresh header strobe", n_str - s0, 1);
    check("R12 fresh header code", last_code, 6'h09);

    // R9 busy at frame start
    s0 = n_str; p0 = n_push;
    exec_busy = 1'b1;
    sel_on(); exec_busy = 1'b0; xfer(8'hC7, 8, g); sel_off();
    check("R9 busy frame no strobe", n_str - s0, 0);
    exec_busy = 1'b1;
    sel_on(); exec_busy = 1'b0; xfer(8'h80, 8, g); xfer(8'h55, 8, g); sel_off();
    check("R9 busy frame no push", n_push - p0, 0);

    // R6 R7 receive read
    rxmem[0] = 8'hB4; rxmem[1] = 8'h1E; rxmem[2] = 8'h6D; rx_tail = 3;
    q0 = n_pop;
    sel_on(); xfer(8'hBF, 8, g);
    check("R6 sdo quiet during header", sdo, 0);
    xfer(8'h00, 8, g); check("R6 first byte", g, 8'hB4);
    xfer(8'h00, 8, g); check("R6 second byte", g, 8'h1E);
    xfer(8'h00, 3, g); check("R6 partial bits", g, 3'b011);
    sel_off();
    check("R7 pops for two full bytes", n_pop - q0, 2);
    sel_on(); xfer(8'hBF, 8, g); xfer(8'h00, 8, g); sel_off();
    check("R7 restored byte read again", g, 8'h6D);
    check("R7 pop after restore", n_pop - q0, 3);

    // R8 empty read
    check("R8 underflow clear before", rx_underflow, 0);
    sel_on(); xfer(8'hBF, 8, g); xfer(8'h00, 8, g); sel_off();
    check("R8 empty reads zero", g, 0);
    check("R8 no pop on empty", n_pop - q0, 3);
    check("R8 underflow set", rx_underflow, 1);

    // R5 cap and overflow
    p0 = n_push;
    check("R5 overflow clear before", tx_overflow, 0);
    sel_on(); xfer(8'h80, 8, g);
    for (int k = 0; k < 34; k++) xfer(8'(k + 1), 8, g);
    sel_off();
    check("R5 pushes capped at 32", n_push - p0, 32);
    check("R5 last kept byte", pushed[6'(p0 + 31)], 8'd32);
    check("R5 overflow flag", tx_overflow, 1);
    sel_on(); xfer(8'hC3, 8, g); sel_off();
    check("R5 overflow sticky", tx_overflow, 1);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; repeat (2) @(negedge clk);
    check("R5 R8 flags cleared by reset", {tx_overflow, rx_underflow}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule